// File: doc/BRIEF.md
# Two-Dimensional Block Parity Encoder and Checker

This block protects blocks of short characters with two crossed parity checks. On the transmit path, each 7-bit character is extended with an eighth bit that makes its count of ones even. When the last character of a block has been sent, one more word follows. This trailing word carries the even parity of every bit position taken down the whole block. Its top bit covers the per-character parity bits, so it always equals the even parity of its own lower seven bits.

On the receive path, the checker takes the extended characters and the trailing parity word. It recomputes both the per-character checks and the per-column checks. One cycle after the trailing word arrives, it gives a single verdict for the whole block: pass or discard. Two counts come with the verdict. One is the number of characters that failed their own check, saturating at 7. The other is the number of bit columns whose parity disagreed.

Both paths are valid/ready byte streams. A first-marker flags the opening character of a block, and a last-marker flags a block boundary. On the encoder input, the last-marker flags the final character. On the encoder output and the checker input, it flags the trailing parity word. A word moves only in a cycle where valid and ready are both high.

The encoder passes back-pressure straight through from its output to its input. While the trailing word waits, the encoder holds its input ready low and keeps the trailing word stable on its output. The checker never back-pressures: its ready is always high. A block must hold at least one character, and a trailing word must never carry the first-marker.

Top module: `blkpar_codec`

## Requirements
- R1: Each character accepted by the encoder leaves in the same cycle as the 8-bit word {p, c}. Here c is the character in bits 6..0, and p in bit 7 makes the word's count of ones even.
- R2: In the cycle after the last character is accepted, the encoder presents a trailing word with its last-marker set. Each bit n of that word is the XOR of bit n of every encoded word in the block. A first-marker starts the accumulation afresh, so each block is independent of the ones before it. Bit 7 of the trailing word is therefore the even parity of its bits 6..0.
- R3: While the trailing word is presented and output ready is low, the trailing word stays valid and unchanged. Encoder input ready stays low until the trailing word has been accepted.
- R4: In the cycle after the checker accepts a trailing word, block_ok pulses for exactly one cycle when every character word and every column has even parity.
- R5: In the same cycle, block_bad pulses instead when any check fails. block_ok and block_bad are never high together, and they are both low in every other cycle.
- R6: A character with an even number of flipped bits passes its own check, so the row count is 0. The block is still discarded through the column check.
- R7: Four flips at the same two bit positions in two different characters defeat both checks. Such a block is reported with block_ok.
- R8: A burst of 8 consecutive flipped bits spread over two characters is detected, and block_bad is raised.
- R9: row_fail_cnt gives the number of characters with odd parity in the block. It saturates at 7.
- R10: col_fail_cnt gives the number of bit positions (0..8) where the column parity and the trailing word disagree.
- R11: rcv_ready is always high. row_fail_cnt and col_fail_cnt change only in a cycle where a verdict is given.
- R12: After reset, no output is valid, no verdict is raised, and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Encoder input character valid |
| src_ready | output | 1 | Encoder can accept a character |
| src_char | input | 7 | Character to encode |
| src_first | input | 1 | Character opens a block |
| src_last | input | 1 | Character closes a block |
| enc_valid | output | 1 | Encoded word valid |
| enc_ready | input | 1 | Downstream accepts encoded word |
| enc_word | output | 8 | Encoded character or trailing parity word |
| enc_first | output | 1 | Word is the first character of a block |
| enc_last | output | 1 | Word is the trailing parity word |
| rcv_valid | input | 1 | Checker input word valid |
| rcv_ready | output | 1 | Checker ready (always high) |
| rcv_word | input | 8 | Received character or trailing word |
| rcv_first | input | 1 | Word is the first character of a block |
| rcv_last | input | 1 | Word is the trailing parity word |
| block_ok | output | 1 | One-cycle pass verdict |
| block_bad | output | 1 | One-cycle discard verdict |
| row_fail_cnt | output | 3 | Failing characters, saturating at 7 |
| col_fail_cnt | output | 4 | Failing bit columns |

## Verification
Some properties hold on every cycle and are checked that way. The trailing word always has even parity. It is held stable under back-pressure, and it blocks new input while it waits. A verdict appears only right after a trailing word, never both ways at once, and a pass always carries zero counts. The row counter never wraps past its ceiling. Other behaviours depend on the data and are shown only by the bench's scenarios, which check the exact encoded words and trailing word against arithmetic XOR sums. These scenarios cover every character value, every single-bit and double-bit corruption position, the rectangle pattern that escapes detection, an 8-bit burst, and count saturation.

// File: rtl/blkpar_pkg.sv
package blkpar_pkg;
  typedef enum logic {
    GEN_PASS = 1'b0,
    GEN_ROW  = 1'b1
  } gen_state_t;

  typedef struct packed {
    logic pass;
    logic fail;
  } verdict_t;
endpackage

// File: rtl/blkpar_satcnt.sv
module blkpar_satcnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         seed,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= {{(W-1){1'b0}}, seed};
    end else if (bump && count != TOP) begin
      count <= count + 1'b1;
    end
  end

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !restart) |=> count == TOP);
endmodule

// File: rtl/blkpar_gen.sv
module blkpar_gen
  import blkpar_pkg::*;
#(
  parameter int CHAR_W = 7,
  localparam int WORD_W = CHAR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_first,
  output logic              out_last
);
  gen_state_t        state;
  logic [WORD_W-1:0] col_acc;
  logic [WORD_W-1:0] row_q;
  logic [WORD_W-1:0] enc;
  logic [WORD_W-1:0] acc_next;
  logic              take;

  always_comb begin
    enc      = {^in_char, in_char};
    acc_next = in_first ? enc : (col_acc ^ enc);
    in_ready = out_ready && (state == GEN_PASS);
    take     = in_valid && in_ready;
    if (state == GEN_ROW) begin
      out_valid = 1'b1;
      out_word  = row_q;
      out_first = 1'b0;
      out_last  = 1'b1;
    end else begin
      out_valid = in_valid;
      out_word  = enc;
      out_first = in_first;
      out_last  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= GEN_PASS;
      col_acc <= '0;
      row_q   <= '0;
    end else begin
      if (take) begin
        col_acc <= acc_next;
        if (in_last) begin
          row_q <= acc_next;
          state <= GEN_ROW;
        end
      end
      if (state == GEN_ROW && out_ready) begin
        state <= GEN_PASS;
      end
    end
  end

  assert_row_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (^out_word) == 1'b0);
  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && !out_ready) |=> (out_valid && out_last && $stable(out_word)));
  assert_row_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !in_ready);
  assert_row_follows_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_last) |-> $past(in_valid && in_ready && in_last));
endmodule

// File: rtl/blkpar_chk.sv
module blkpar_chk
  import blkpar_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ROWCNT_W = 3,
  localparam int COLCNT_W = $clog2(WORD_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                in_first,
  input  logic                in_last,
  output logic                ok,
  output logic                bad,
  output logic [ROWCNT_W-1:0] row_fails,
  output logic [COLCNT_W-1:0] col_fails
);
  logic [WORD_W-1:0]   col_acc;
  logic [WORD_W-1:0]   col_diff;
  logic [COLCNT_W-1:0] diff_ones;
  logic [ROWCNT_W-1:0] row_run;
  logic                is_char;
  logic                is_row;
  logic                odd;
  verdict_t            verdict;

  assign in_ready = 1'b1;

  always_comb begin
    is_char  = in_valid && !in_last;
    is_row   = in_valid && in_last;
    odd      = ^in_word;
    col_diff = col_acc ^ in_word;
    diff_ones = '0;
    for (int b = 0; b < WORD_W; b++) begin
      diff_ones = diff_ones + COLCNT_W'(col_diff[b]);
    end
    verdict.pass = (row_run == '0) && (col_diff == '0);
    verdict.fail = !verdict.pass;
  end

  blkpar_satcnt #(.W(ROWCNT_W)) i_rowcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (is_char && in_first),
    .seed    (odd),
    .bump    (is_char && !in_first && odd),
    .count   (row_run)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_acc   <= '0;
      ok        <= 1'b0;
      bad       <= 1'b0;
      row_fails <= '0;
      col_fails <= '0;
    end else begin
      ok  <= 1'b0;
      bad <= 1'b0;
      if (is_char) begin
        col_acc <= in_first ? in_word : (col_acc ^ in_word);
      end
      if (is_row) begin
        ok        <= verdict.pass;
        bad       <= verdict.fail;
        row_fails <= row_run;
        col_fails <= diff_ones;
      end
    end
  end

  always_comb begin
    assert_always_ready_R11: assert (in_ready == 1'b1);
  end

  assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, bad}));
  assert_verdict_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || bad) |-> $past(in_valid && in_last));
  assert_verdict_after_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (ok || bad));
  assert_pass_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (row_fails == '0 && col_fails == '0));
  assert_counts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok || bad) |-> ($stable(row_fails) && $stable(col_fails)));
endmodule

// File: rtl/blkpar_codec.sv
module blkpar_codec #(
  parameter int CHAR_W = 7,
  parameter int ROWCNT_W = 3,
  localparam int WORD_W = CHAR_W + 1,
  localparam int COLCNT_W = $clog2(WORD_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_valid,
  output logic                src_ready,
  input  logic [CHAR_W-1:0]   src_char,
  input  logic                src_first,
  input  logic                src_last,
  output logic                enc_valid,
  input  logic                enc_ready,
  output logic [WORD_W-1:0]   enc_word,
  output logic                enc_first,
  output logic                enc_last,
  input  logic                rcv_valid,
  output logic                rcv_ready,
  input  logic [WORD_W-1:0]   rcv_word,
  input  logic                rcv_first,
  input  logic                rcv_last,
  output logic                block_ok,
  output logic                block_bad,
  output logic [ROWCNT_W-1:0] row_fail_cnt,
  output logic [COLCNT_W-1:0] col_fail_cnt
);
  blkpar_gen #(.CHAR_W(CHAR_W)) i_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (src_valid),
    .in_ready  (src_ready),
    .in_char   (src_char),
    .in_first  (src_first),
    .in_last   (src_last),
    .out_valid (enc_valid),
    .out_ready (enc_ready),
    .out_word  (enc_word),
    .out_first (enc_first),
    .out_last  (enc_last)
  );

  blkpar_chk #(.WORD_W(WORD_W), .ROWCNT_W(ROWCNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rcv_valid),
    .in_ready  (rcv_ready),
    .in_word   (rcv_word),
    .in_first  (rcv_first),
    .in_last   (rcv_last),
    .ok        (block_ok),
    .bad       (block_bad),
    .row_fails (row_fail_cnt),
    .col_fails (col_fail_cnt)
  );
endmodule

// File: tb/test_blkpar_codec.sv
module test_blkpar_codec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_valid, src_ready, src_first, src_last;
  logic [6:0] src_char;
  logic       enc_valid, enc_ready, enc_first, enc_last;
  logic [7:0] enc_word;
  logic       rcv_valid, rcv_ready, rcv_first, rcv_last;
  logic [7:0] rcv_word;
  logic       block_ok, block_bad;
  logic [2:0] row_fail_cnt;
  logic [3:0] col_fail_cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] blk [16];
  logic [7:0] row;

  always #2 clk = ~clk;

  blkpar_codec i_blkpar_codec (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] encode(input logic [6:0] c);
    return {^c, c};
  endfunction

  // Build n clean words from a seed and their column row.
  task automatic build(input int n, input int seed);
    row = '0;
    for (int i = 0; i < n; i++) begin
      blk[i] = encode(7'((seed * 37 + i * 53 + 11) & 7'h7f));
      row ^= blk[i];
    end
  endtask

  task automatic send_block(input string req, input int n, input int exp_ok,
                            input int exp_rows, input int exp_cols);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rcv_valid = 1'b1; rcv_word = blk[i];
      rcv_first = (i == 0); rcv_last = 1'b0;
    end
    @(negedge clk);
    rcv_word = row; rcv_first = 1'b0; rcv_last = 1'b1;
    @(negedge clk);
    rcv_valid = 1'b0; rcv_last = 1'b0;
    check({req, " ok"}, int'(block_ok), exp_ok);
    check({req, " bad"}, int'(block_bad), 1 - exp_ok);
    check({req, " rows"}, int'(row_fail_cnt), exp_rows);
    check({req, " cols"}, int'(col_fail_cnt), exp_cols);
    check("R11 ready", int'(rcv_ready), 1);
    @(negedge clk);
    check("R5 pulse ends", int'(block_ok | block_bad), 0);
    check("R11 counts held", int'(row_fail_cnt) * 16 + int'(col_fail_cnt),
          exp_rows * 16 + exp_cols);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    rst_n = 1'b0;
    src_valid = 0; src_first = 0; src_last = 0; src_char = '0; enc_ready = 1;
    rcv_valid = 0; rcv_first = 0; rcv_last = 0; rcv_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 enc_valid", int'(enc_valid), 0);
    check("R12 verdict", int'(block_ok | block_bad), 0);
    check("R12 counts", int'(row_fail_cnt) + int'(col_fail_cnt), 0);

    // Encoder: two blocks, the first sweeping every character value.
    for (int b = 0; b < 2; b++) begin
      int n = (b == 0) ? 128 : 3;
      acc = '0;
      for (int i = 0; i < n; i++) begin
        logic [6:0] c = (b == 0) ? 7'(i) : 7'(i * 29 + 5);
        src_valid = 1; src_char = c; src_first = (i == 0); src_last = (i == n - 1);
        #1;
        acc ^= encode(c);
        check("R1 word", int'(enc_word), int'(encode(c)));
        check("R1 valid", int'(enc_valid && !enc_last), 1);
        @(negedge clk);
      end
      src_valid = 0; src_last = 0; enc_ready = 0;
      #1;
      check("R2 row", int'(enc_word), int'(acc));
      check("R2 row marker", int'(enc_valid && enc_last), 1);
      check("R2 row bit7", int'(enc_word[7]), int'(^enc_word[6:0]));
      check("R3 input blocked", int'(src_ready), 0);
      @(negedge clk);
      check("R3 row held", int'(enc_word), int'(acc));
      check("R3 valid held", int'(enc_valid && enc_last), 1);
      enc_ready = 1;
      @(negedge clk);
      check("R3 released", int'(enc_valid), 0);
      check("R3 ready back", int'(src_ready), 1);
    end

    // Checker: clean blocks of several lengths.
    for (int n = 1; n <= 6; n++) begin
      build(n, n);
      send_block("R4 clean", n, 1, 0, 0);
    end
    // Single flips at every position of several characters.
    for (int c = 0; c < 3; c++) begin
      for (int bit_i = 0; bit_i < 8; bit_i++) begin
        build(3, c + bit_i);
        blk[c][bit_i] = ~blk[c][bit_i];
        send_block("R5 single flip", 3, 0, 1, 1);
      end
    end
    // Corrupted trailing word, every bit.
    for (int bit_i = 0; bit_i < 8; bit_i++) begin
      build(4, bit_i);
      row[bit_i] = ~row[bit_i];
      send_block("R10 row word flip", 4, 0, 0, 1);
    end
    // Double flips in one character: row check passes, columns catch it.
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        build(3, i * 8 + j);
        blk[1][i] = ~blk[1][i];
        blk[1][j] = ~blk[1][j];
        send_block("R6 double flip", 3, 0, 0, 2);
      end
    end
    // Rectangle of four flips escapes both checks.
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        build(4, i + j);
        blk[0][i] = ~blk[0][i]; blk[0][j] = ~blk[0][j];
        blk[2][i] = ~blk[2][i]; blk[2][j] = ~blk[2][j];
        send_block("R7 rectangle", 4, 1, 0, 0);
      end
    end
    // 8-bit burst: high nibble of char 1, low nibble of char 2.
    build(4, 9);
    blk[1][7:4] = ~blk[1][7:4];
    blk[2][3:0] = ~blk[2][3:0];
    send_block("R8 burst", 4, 0, 0, 8);
    // Saturation: ten single flips in column 0 (even count per column).
    build(10, 3);
    for (int i = 0; i < 10; i++) blk[i][0] = ~blk[i][0];
    send_block("R9 saturate", 10, 0, 7, 0);
    // Exactly seven failing rows, odd column count.
    build(7, 5);
    for (int i = 0; i < 7; i++) blk[i][3] = ~blk[i][3];
    send_block("R9 seven rows", 7, 0, 7, 1);
    // New block after failure starts clean.
    build(2, 8);
    send_block("R4 restart", 2, 1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule